// File: doc/BRIEF.md
# Periodic Interval Timer

This peripheral produces a steady interrupt rate from a single clock-enable pulse. A 20-bit interval counter advances once per tick. When it reaches a programmed period value it returns to zero, raises a status flag and adds one to a 12-bit count of completed periods. Software sets the period and the two enable bits through a mode register. It polls the flag through a status register. It reads the counter and the period count either through a value register, which acknowledges everything, or through an image register, which only observes.

The bus is a plain strobe interface. `bus_rd` or `bus_wr` is held for one clock, with an address and write data. Read data is combinational from the current state. Any side effect of a read takes place at the clock edge that ends the access. Only the low four address bits are decoded, so the register set repeats through the address space. Clearing the enable bit gives a graceful stop: the counter finishes its current interval, wraps once more and then rests at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset the mode register, the status register and the image register all read 0, and `irq` is low.
- R2: The mode register is at offset 0x0. It holds the period in bits 19:0, the enable in bit 24 and the interrupt enable in bit 25. All other written bits are discarded and read back as 0.
- R3: While enabled, each cycle with `tick_en` high adds one to the counter. A cycle without `tick_en` leaves the counter unchanged.
- R4: A tick that finds the counter at or above the period value sets the counter to 0, sets the status flag and adds one to the period count.
- R5: The period count saturates at 4095 and does not wrap.
- R6: `irq` is high exactly when the status flag is set and the interrupt enable (bit 25) is 1.
- R7: A read of the value register (offset 0x8) returns the period count in bits 31:20 and the counter in bits 19:0, using the values from before the read. After the read, the status flag, `irq` and the period count are cleared.
- R8: A read of the image register (offset 0xC) returns the same layout as the value register and changes no state.
- R9: After the enable is cleared, ticks keep advancing the counter up to the period value. The wrap still sets the flag. The counter then stays at 0.
- R10: Only address bits 3:0 are decoded. The status register at 0x4 reports the flag in bit 0. Any other offset reads 0.
- R11: If a wrap and a value-register read fall in the same cycle, the status flag stays set and the period count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse, one per counter step |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address, low 4 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- Each strobe is sampled at one clock edge only.
- Any tick during an access is meant to interact with that access.

The directed tasks raise one strobe at a time, for exactly one cycle, and drive both strobes and `tick_en` on the falling edge. A tick is paired with a value-register read only in the dedicated same-cycle race scenario. Elsewhere the bench keeps ticks and bus accesses apart, so the expected register values can be counted tick by tick.

// File: rtl/pit_pkg.sv
// Shared constants for the periodic interval timer: register offsets
// and bit positions of the mode fields. Assumes 32-bit registers.
package pit_pkg;
    localparam int REG_W   = 32;
    localparam int EN_BIT  = 24;
    localparam int IEN_BIT = 25;
    localparam logic [3:0] OFS_MODE = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_VAL  = 4'h8;
    localparam logic [3:0] OFS_IMG  = 4'hC;
endpackage

// File: rtl/pit_mode_reg.sv
// Mode register: stores the period value and the two enable bits.
// Assumes the caller has already decoded the write strobe to this offset.
module pit_mode_reg #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic [CNT_W-1:0] wr_period,
    input  logic             wr_en,
    input  logic             wr_ien,
    output logic [CNT_W-1:0] period,
    output logic             en,
    output logic             ien
);
    // Capture the mode fields on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            en     <= 1'b0;
            ien    <= 1'b0;
        end else if (wr_mode) begin
            period <= wr_period;
            en     <= wr_en;
            ien    <= wr_ien;
        end
    end
endmodule

// File: rtl/pit_interval_ctr.sv
// Interval counter: steps on each tick while enabled, or while a run-on
// after disable is still under way. Wraps to zero at or above the period.
// Assumes the period may change at any time; a counter above the new
// period wraps on its next tick.
module pit_interval_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic active;
    logic at_limit;

    // Keep running while enabled, or until the interval in flight completes.
    assign active   = en || (cnt != '0);
    assign at_limit = (cnt >= period);
    assign wrap     = tick && active && at_limit;

    // Advance or wrap the counter on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick && active)
            cnt <= at_limit ? '0 : cnt + 1'b1;
    end

    AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && cnt == '0) |=> (cnt == '0)); // R9
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R3
endmodule

// File: rtl/pit_period_acct.sv
// Period accounting: holds the status flag and the saturating count of
// completed periods. A wrap takes priority over a clearing read.
module pit_period_acct #(
    parameter int PCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              clr,
    output logic              flag,
    output logic [PCNT_W-1:0] pcnt
);
    localparam logic [PCNT_W-1:0] PCNT_MAX = '1;

    // Record wraps and apply acknowledge-by-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            pcnt <= '0;
        end else if (wrap) begin
            flag <= 1'b1;
            if (clr)
                pcnt <= PCNT_W'(1);
            else if (pcnt != PCNT_MAX)
                pcnt <= pcnt + 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
            pcnt <= '0;
        end
    end

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pcnt == PCNT_MAX && !clr) |=> (pcnt == PCNT_MAX)); // R5
    AST_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wrap) |=> (!flag && pcnt == '0)); // R7
    AST_RACE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && wrap) |=> (flag && pcnt == PCNT_W'(1))); // R11
endmodule

// File: rtl/pit_timer.sv
// Periodic interval timer top: decodes the low four address bits,
// wires the mode register, interval counter and period accounting,
// and muxes read data. Assumes single-cycle strobes that never overlap.
module pit_timer
    import pit_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 20,
    parameter int PCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int VAL_W = CNT_W + PCNT_W;

    logic [3:0]        ofs;
    logic              wr_mode;
    logic              clr;
    logic [CNT_W-1:0]  period;
    logic              en;
    logic              ien;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              flag;
    logic [PCNT_W-1:0] pcnt;
    logic [VAL_W-1:0]  val_word;

    // Decode only the low four address bits.
    assign ofs     = bus_addr[3:0];
    assign wr_mode = bus_wr && (ofs == OFS_MODE);
    assign clr     = bus_rd && (ofs == OFS_VAL);

    pit_mode_reg #(.CNT_W(CNT_W)) mode_i (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode),
        .wr_period(bus_wdata[CNT_W-1:0]), .wr_en(bus_wdata[EN_BIT]),
        .wr_ien(bus_wdata[IEN_BIT]),
        .period(period), .en(en), .ien(ien)
    );

    pit_interval_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .en(en),
        .period(period), .cnt(cnt), .wrap(wrap)
    );

    pit_period_acct #(.PCNT_W(PCNT_W)) acct_i (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .clr(clr),
        .flag(flag), .pcnt(pcnt)
    );

    // Gate the status flag with the interrupt enable.
    assign irq      = flag & ien;
    assign val_word = {pcnt, cnt};

    // Select read data from current state; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (ofs)
            OFS_MODE: begin
                bus_rdata[CNT_W-1:0] = period;
                bus_rdata[EN_BIT]    = en;
                bus_rdata[IEN_BIT]   = ien;
            end
            OFS_STAT: bus_rdata[0] = flag;
            OFS_VAL,
            OFS_IMG:  bus_rdata = REG_W'(val_word);
            default:  bus_rdata = '0;
        endcase
    end

    AST_IMAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ofs == OFS_IMG && !wrap) |=> ($stable(flag) && $stable(pcnt))); // R8
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wrap) |=> !irq); // R7
endmodule

// File: tb/pit_timer_tb.sv
// Directed bench for pit_timer: one task per scenario, each checking itself.
module pit_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_checks = 0;
    int          n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic tk, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; tick_en = tk;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(8'h00, 1'b0, d); check("R1 mode", d, 32'h0);
        bus_read(8'h04, 1'b0, d); check("R1 status", d, 32'h0);
        bus_read(8'h0C, 1'b0, d); check("R1 image", d, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        bus_write(8'h00, 32'hFCF0_0007);
        bus_read(8'h00, 1'b0, d); check("R2 reserved dropped", d, 32'h0000_0007);
        bus_write(8'h00, 32'h0200_0007);
        bus_read(8'h00, 1'b0, d); check("R2 ien field", d, 32'h0200_0007);
    endtask

    task automatic t_count_wrap();
        logic [31:0] d;
        bus_write(8'h00, 32'h0100_0009);
        ticks(4);
        bus_read(8'h0C, 1'b0, d); check("R3 four ticks", d, 32'h0000_0004);
        idle(3);
        bus_read(8'h0C, 1'b0, d); check("R3 no tick hold", d, 32'h0000_0004);
        ticks(6);
        bus_read(8'h0C, 1'b0, d); check("R4 wrap image", d, 32'h0010_0000);
        bus_read(8'h04, 1'b0, d); check("R4 status set", d, 32'h1);
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        bus_read(8'h0C, 1'b0, d); check("R8 image repeat", d, 32'h0010_0000);
        bus_read(8'h04, 1'b0, d); check("R8 status kept", d, 32'h1);
        bus_write(8'h00, 32'h0300_0009);
        check("R6 irq enabled", {31'b0, irq}, 32'h1);
        bus_read(8'h08, 1'b0, d); check("R7 value returns old count", d, 32'h0010_0000);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        bus_read(8'h04, 1'b0, d); check("R7 status cleared", d, 32'h0);
        bus_read(8'h0C, 1'b0, d); check("R7 count cleared", d, 32'h0);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        bus_write(8'h00, 32'h0100_0000);
        ticks(4100);
        bus_read(8'h0C, 1'b0, d); check("R5 saturated", d, 32'hFFF0_0000);
        bus_read(8'h08, 1'b0, d); check("R5 value at max", d, 32'hFFF0_0000);
        bus_read(8'h0C, 1'b0, d); check("R7 cleared after max", d, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        bus_write(8'h00, 32'h0100_0009);
        ticks(3);
        bus_write(8'h00, 32'h0000_0009);
        ticks(2);
        bus_read(8'h0C, 1'b0, d); check("R9 runs on", d, 32'h0000_0005);
        ticks(5);
        bus_read(8'h0C, 1'b0, d); check("R9 final wrap", d, 32'h0010_0000);
        ticks(3);
        bus_read(8'h0C, 1'b0, d); check("R9 rests at zero", d, 32'h0010_0000);
        bus_read(8'h04, 1'b0, d); check("R9 wrap flagged", d, 32'h1);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        bus_read(8'h14, 1'b0, d); check("R10 status alias", d, 32'h1);
        bus_read(8'h02, 1'b0, d); check("R10 unmapped", d, 32'h0);
        bus_read(8'h1C, 1'b0, d); check("R10 image alias", d, 32'h0010_0000);
        bus_write(8'h10, 32'h0000_0003);
        bus_read(8'h00, 1'b0, d); check("R10 mode alias write", d, 32'h0000_0003);
    endtask

    task automatic t_race();
        logic [31:0] d;
        bus_write(8'h00, 32'h0100_0002);
        bus_read(8'h08, 1'b0, d);
        bus_read(8'h0C, 1'b0, d); check("R11 start clean", d, 32'h0);
        ticks(2);
        bus_read(8'h08, 1'b1, d); check("R11 read value", d, 32'h0000_0002);
        bus_read(8'h0C, 1'b0, d); check("R11 count one", d, 32'h0010_0000);
        bus_read(8'h04, 1'b0, d); check("R11 status kept", d, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_count_wrap();
        t_saturate();
        t_disable();
        t_decode();
        t_race();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule